// File: doc/BRIEF.md
# Multi-channel memory bus arbiter with burst grouping

This block shares one memory bus among several DMA channels. Each channel moves data words either toward external memory or away from it. A channel asks for the bus with a request line, a direction bit and an urgent flag. Its burst length and priority come in as configuration fields. The arbiter grants the bus to one channel at a time. While the grant is high, the channel moves one word per clock, so a running burst has no idle cycles.

A granted channel keeps the bus for its programmed number of consecutive words. This keeps traffic in one direction together and avoids turning the bus around on every word. When the next owner's direction differs from the last one, the arbiter holds the bus idle for a fixed turnaround gap and flags that gap on its own output.

Contention is settled in a fixed order. Urgent requests win first. Priority level comes next. Channels of equal priority are served in round-robin order.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle. A grant bit is high only while that channel's `req` is high. Each cycle with a grant bit high moves exactly one word.
- R2: A channel's burst field sits at `burst_len_m1[4i+3:4i]` and holds the word count minus one. A granted channel receives exactly that many plus one consecutive grant cycles, which gives 1 to 16 words.
- R3: A channel's priority field sits at `prio[2i+1:2i]`. Among the competing channels, the one with the larger value wins.
- R4: Among competing channels of equal priority, the search starts at the channel just after the last one granted and wraps around. After reset the search starts at channel 0.
- R5: A channel competes as urgent only when its `urgent` and `req` are both high. If any urgent channel exists, only urgent channels compete. An `urgent` bit with its `req` low has no effect.
- R6: A new ordinary request never shortens a running burst, whatever its priority. An urgent request from another channel ends the burst after the word moving in that cycle, unless the owner itself is urgent.
- R7: If the owner lowers `req` during its burst, its grant falls in that same cycle. The bus is then re-arbitrated in the following cycle.
- R8: When a new owner's direction differs from the previous owner's, `turn` is high for exactly 2 cycles with no grant, and then the burst starts. Direction bit 1 means toward external memory. `bus_dir` shows the owner's direction during its burst.
- R9: Between two bursts in the same direction there is exactly one cycle with no grant, which is the arbitration cycle. The first grant after reset never has a turnaround gap.
- R10: During and right after reset, `gnt` is all zero and `turn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-channel bus request |
| dir | input | 4 | Per-channel direction, 1 = toward external memory |
| urgent | input | 4 | Per-channel urgent flag |
| burst_len_m1 | input | 16 | Per-channel burst length minus one, 4 bits each |
| prio | input | 8 | Per-channel priority, 2 bits each, larger wins |
| gnt | output | 4 | One-hot grant; a word moves on each granted cycle |
| bus_dir | output | 1 | Direction of the current or pending owner |
| turn | output | 1 | High during the direction-change gap |

## Verification
An urgent request and the word transfer of a running burst can land in the same cycle. The same cycle then both moves a word and ends the burst. The bench provokes this by raising another channel's request and urgent flag right after the third word of an 8-word burst. It judges the result by a burst length of exactly 3, followed by a grant to the urgent channel with no turnaround. The same kind of overlap between a dropped request and a burst in progress is checked as well: the grant must fall in that cycle, and the other channel must follow after exactly one arbitration cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_ARB   = 2'd0,
    ST_TURN  = 2'd1,
    ST_BURST = 2'd2
  } arb_st_t;

  // Round-robin distance: 0 means the channel right after the last granted one.
  function automatic logic [7:0] rr_dist(input logic [7:0] idx,
                                         input logic [7:0] last,
                                         input logic [7:0] n);
    return 8'((idx + n - last - 8'd1) % n);
  endfunction

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic [NCH-1:0]        req,
  input  logic [NCH-1:0]        urgent,
  input  logic [NCH*PRIO_W-1:0] prio,
  input  logic [IDX_W-1:0]      last_idx,
  output logic                  win_vld,
  output logic [IDX_W-1:0]      win_idx
);

  logic [NCH-1:0]    hot;
  logic [NCH-1:0]    cand;
  logic [PRIO_W-1:0] best_p;
  logic [7:0]        best_d;
  logic [7:0]        d;
  logic [PRIO_W-1:0] p;
  logic              found;

  assign hot     = req & urgent;
  assign cand    = (|hot) ? hot : req;
  assign win_vld = |cand;

  always_comb begin
    win_idx = '0;
    best_p  = '0;
    best_d  = '1;
    found   = 1'b0;
    d       = '0;
    p       = '0;
    for (int i = 0; i < NCH; i++) begin
      p = prio[i*PRIO_W +: PRIO_W];
      d = rr_dist(8'(i), 8'(last_idx), 8'(NCH));
      if (cand[i] && (!found || p > best_p || (p == best_p && d < best_d))) begin
        found   = 1'b1;
        best_p  = p;
        best_d  = d;
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dma_arb_burst_ctr.sv
module dma_arb_burst_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             step,
  output logic             last
);

  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)                    left <= '0;
    else if (load)                 left <= len_m1;
    else if (step && left != '0)   left <= left - 1'b1;
  end

  assign last = (left == '0);

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int LEN_W    = 4,
  parameter int PRIO_W   = 2,
  parameter int TURN_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        req,
  input  logic [NCH-1:0]        dir,
  input  logic [NCH-1:0]        urgent,
  input  logic [NCH*LEN_W-1:0]  burst_len_m1,
  input  logic [NCH*PRIO_W-1:0] prio,
  output logic [NCH-1:0]        gnt,
  output logic                  bus_dir,
  output logic                  turn
);

  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TC_W  = $clog2(TURN_CYC + 1);

  arb_st_t          st;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] rr_last;
  logic [TC_W-1:0]  tcnt;
  logic             have_dir;

  // Named internal events
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [NCH-1:0]   owner_oh;
  logic             in_burst;
  logic             word_xfer;
  logic             urg_other;
  logic             preempt;
  logic             burst_last;
  logic             burst_end;
  logic             req_drop;
  logic             arb_fire;
  logic             need_turn;

  dma_arb_pick #(.NCH(NCH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .req(req), .urgent(urgent), .prio(prio), .last_idx(rr_last),
    .win_vld(win_vld), .win_idx(win_idx)
  );

  dma_arb_burst_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(arb_fire),
    .len_m1(burst_len_m1[int'(win_idx)*LEN_W +: LEN_W]),
    .step(word_xfer), .last(burst_last)
  );

  assign owner_oh  = NCH'(1) << owner;
  assign in_burst  = (st == ST_BURST);
  assign gnt       = in_burst ? (owner_oh & req) : '0;
  assign word_xfer = |gnt;
  assign urg_other = |(urgent & req & ~owner_oh);
  assign preempt   = word_xfer && urg_other && !urgent[owner];
  assign burst_end = word_xfer && (burst_last || preempt);
  assign req_drop  = in_burst && !req[owner];
  assign arb_fire  = (st == ST_ARB) && win_vld;
  assign need_turn = arb_fire && have_dir && (dir[win_idx] != bus_dir);
  assign turn      = (st == ST_TURN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_ARB;
      owner    <= '0;
      rr_last  <= IDX_W'(NCH - 1);
      tcnt     <= '0;
      have_dir <= 1'b0;
      bus_dir  <= 1'b0;
    end else begin
      unique case (st)
        ST_ARB: if (arb_fire) begin
          owner    <= win_idx;
          rr_last  <= win_idx;
          bus_dir  <= dir[win_idx];
          have_dir <= 1'b1;
          if (need_turn) begin
            st   <= ST_TURN;
            tcnt <= TC_W'(TURN_CYC - 1);
          end else begin
            st <= ST_BURST;
          end
        end
        ST_TURN: begin
          if (tcnt == '0) st <= ST_BURST;
          else            tcnt <= tcnt - 1'b1;
        end
        ST_BURST: if (req_drop || burst_end) st <= ST_ARB;
        default: st <= ST_ARB;
      endcase
    end
  end

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH      = 4,
  parameter int LEN_W    = 4,
  parameter int TURN_CYC = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] gnt,
  input logic           turn,
  input logic           bus_dir,
  input logic           word_xfer,
  input logic           burst_end,
  input logic           need_turn
);

  localparam int TC_W = $clog2(TURN_CYC + 1);

  logic [NCH-1:0]  gnt_q;
  logic            dir_q;
  logic [LEN_W:0]  run_cnt;
  logic [TC_W-1:0] turn_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      dir_q    <= 1'b0;
      run_cnt  <= '0;
      turn_run <= '0;
    end else begin
      gnt_q    <= gnt;
      dir_q    <= bus_dir;
      run_cnt  <= !word_xfer ? '0 : (gnt == gnt_q) ? run_cnt + 1'b1 : (LEN_W+1)'(1);
      turn_run <= turn ? turn_run + 1'b1 : '0;
    end
  end

  a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  a_r2_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (word_xfer && gnt == gnt_q) |-> !run_cnt[LEN_W]);

  a_r8_turn_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    turn |-> gnt == '0);

  a_r8_turn_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    need_turn |=> turn);

  a_r8_turn_width: assert property (@(posedge clk) disable iff (!rst_n)
    turn |-> turn_run < TC_W'(TURN_CYC));

  a_r8_dir_steady_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (word_xfer && gnt == gnt_q) |-> bus_dir == dir_q);

  a_r9_gap_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> gnt == '0);

endmodule

bind dma_bus_arbiter dma_arb_checker #(.NCH(NCH), .LEN_W(LEN_W), .TURN_CYC(TURN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .turn(turn), .bus_dir(bus_dir),
  .word_xfer(word_xfer), .burst_end(burst_end), .need_turn(need_turn)
);

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0, dir = '0, urgent = '0;
  logic [15:0] blen = '0;
  logic [7:0]  prio = '0;
  logic [3:0]  gnt;
  logic        bus_dir, turn;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .dir(dir), .urgent(urgent),
    .burst_len_m1(blen), .prio(prio), .gnt(gnt), .bus_dir(bus_dir), .turn(turn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(gnt == 4'b0 && turn == 1'b0, "R10 quiet in reset", int'({gnt, turn}), 0);
    rst_n = 1'b1;
  endtask

  // Waits for a grant, counting idle samples and turn samples before it,
  // then counts the consecutive samples with the same grant.
  task automatic measure(output logic [3:0] g, output int len, output int gap,
                         output int turns, output logic bd);
    gap = 0; turns = 0; len = 0; g = '0; bd = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (gnt != 4'b0) break;
      gap++;
      if (turn) turns++;
    end
    g = gnt; bd = bus_dir;
    if (g == 4'b0) return;
    len = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (gnt != g) break;
      len++;
    end
  endtask

  // {req, dir, urgent, prio, burst_len_m1, exp_idx, exp_len}
  localparam logic [42:0] VEC [8] = '{
    {4'b0001, 4'b0000, 4'b0000, 8'b00_00_00_00, 16'h0003, 2'd0, 5'd4},   // R1 R2 single requester
    {4'b1111, 4'b0000, 4'b0000, 8'b00_00_00_00, 16'h3210, 2'd0, 5'd1},   // R4 tie starts at ch0
    {4'b1010, 4'b0000, 4'b0000, 8'b01_00_10_00, 16'h0050, 2'd1, 5'd6},   // R3 higher level wins
    {4'b1111, 4'b0000, 4'b0000, 8'b00_11_00_00, 16'h0F00, 2'd2, 5'd16},  // R2 R3 16-word burst
    {4'b1111, 4'b0000, 4'b1000, 8'b00_00_00_11, 16'h2000, 2'd3, 5'd3},   // R5 urgent beats priority
    {4'b1111, 4'b0000, 4'b0110, 8'b00_10_01_00, 16'h0700, 2'd2, 5'd8},   // R5 priority among urgent
    {4'b0110, 4'b0000, 4'b1001, 8'b00_00_00_00, 16'h0010, 2'd1, 5'd2},   // R5 urgent without req ignored
    {4'b1100, 4'b0000, 4'b0000, 8'b00_00_00_00, 16'h0000, 2'd2, 5'd1}    // R4 R2 one-word burst
  };

  initial begin
    logic [3:0] g;
    logic       bd;
    int         len, gap, turns, n;

    // Vector walk
    for (int k = 0; k < 8; k++) begin
      req    = VEC[k][42:39];
      dir    = VEC[k][38:35];
      urgent = VEC[k][34:31];
      prio   = VEC[k][30:23];
      blen   = VEC[k][22:7];
      do_reset();
      measure(g, len, gap, turns, bd);
      chk(g == (4'b0001 << VEC[k][6:5]), $sformatf("R3 R4 R5 vec%0d winner", k),
          int'(g), int'(4'b0001 << VEC[k][6:5]));
      chk(len == int'(VEC[k][4:0]), $sformatf("R2 vec%0d burst length", k),
          len, int'(VEC[k][4:0]));
      chk(turns == 0, $sformatf("R9 vec%0d no gap after reset", k), turns, 0);
    end

    // R4 rotation and R9 same-direction gap
    req = 4'b0011; dir = 4'b0000; urgent = '0; prio = '0; blen = '0;
    do_reset();
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0001, "R4 rotation first", int'(g), 1);
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0010, "R4 rotation second", int'(g), 2);
    chk(gap == 0 && turns == 0, "R9 single arbitration cycle", gap, 0);
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0001, "R4 rotation wraps", int'(g), 1);

    // R8 turnaround between opposite directions
    req = 4'b0011; dir = 4'b0010; blen = '0;
    do_reset();
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0001 && bd == 1'b0, "R8 first owner reads", int'({g, bd}), 2);
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0010, "R8 second owner", int'(g), 2);
    chk(turns == 2 && gap == 2, "R8 two-cycle turnaround", turns, 2);
    chk(bd == 1'b1, "R8 bus direction writes", int'(bd), 1);
    measure(g, len, gap, turns, bd);
    chk(turns == 2 && bd == 1'b0, "R8 turnaround back", turns, 2);

    // R6 ordinary request does not shorten a burst
    req = 4'b0001; dir = '0; prio = '0; blen = 16'h0007;
    do_reset();
    for (int i = 0; i < 50 && gnt == 4'b0; i++) @(negedge clk);
    n = 1;
    req = 4'b0011; prio = 8'b00_00_11_00;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (gnt != 4'b0001) break;
      n++;
    end
    chk(n == 8, "R6 burst kept against ordinary request", n, 8);
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0010, "R3 waiting high priority served next", int'(g), 2);

    // R6 urgent request ends the burst after the current word
    req = 4'b0001; dir = '0; prio = '0; urgent = '0; blen = 16'h0007;
    do_reset();
    for (int i = 0; i < 50 && gnt == 4'b0; i++) @(negedge clk);
    n = 1;
    for (int i = 0; i < 50; i++) begin
      if (n == 3) begin
        req = 4'b0101; urgent = 4'b0100;
      end
      @(negedge clk);
      if (gnt != 4'b0001) break;
      n++;
    end
    chk(n == 3, "R6 urgent cuts burst at word boundary", n, 3);
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0100 && gap == 0, "R6 urgent channel granted next", int'(g), 4);

    // R7 request dropped mid-burst
    req = 4'b0011; dir = '0; urgent = '0; prio = 8'b00_00_00_01; blen = 16'h0007;
    do_reset();
    for (int i = 0; i < 50 && gnt == 4'b0; i++) @(negedge clk);
    chk(gnt == 4'b0001, "R7 owner granted", int'(gnt), 1);
    @(negedge clk);
    req = 4'b0010;
    #1;
    chk(gnt == 4'b0000, "R7 grant falls with request", int'(gnt), 0);
    measure(g, len, gap, turns, bd);
    chk(g == 4'b0010 && gap == 1, "R7 next owner after one arbitration cycle", gap, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule